// File: doc/BRIEF.md
# Panel Control Register Write Controller

This block is a write-only SPI master for a display panel. The panel's control registers are reached by index. Each register write goes out as two 24-bit frames, and each frame has its own chip-select pulse. The first frame is an index frame that names the register. The second frame is a data frame that carries the 16-bit value. Every frame begins with a fixed command byte that tells the panel which kind of frame it is.

Besides single writes, the block runs two built-in sequences:
- A power-up request switches the panel on and then programs the driver output control register from a parameterised scan and colour-order mode.
- A power-down request puts the panel into shutdown.

The serial clock idles high (SPI mode 3). It is derived from the system clock through a half-period divider, so with a 100 MHz clock the default divider gives an SCK below 20 MHz. `busy_o` covers a whole request. `done_o` pulses once when the request ends.

Top module: `panel_spi_writer`

## Requirements
- R1: SCK (`sck_o`) is high whenever `cs_n_o` is high. Within a frame, MOSI changes only on falling SCK edges, so the panel samples it on rising edges.
- R2: Every chip-select low pulse contains exactly 24 rising SCK edges, and bits go out MSB first.
- R3: A command write to register `r` with value `v` produces two frames. The first is the index frame 0x74, 0x00, `r`. The second is the data frame 0x76, `v[15:8]`, `v[7:0]`.
- R4: Between any two frames, `cs_n_o` stays high for at least 2*HALF_DIV clock cycles, which is one SCK period.
- R5: A power-up request writes register 0x11 = 0x0000, then register 0x01 = (DRV_MODE & 0x2B00) | 0x00EF. The bits of DRV_MODE are: bit 8 left-to-right scan, bit 9 top-to-bottom, bit 11 BGR order, bit 13 normal display. With the default mode 0x2A00 the second value is 0x2AEF.
- R6: A power-down request writes register 0x11 = 0x0001.
- R7: A request is accepted on a clock edge where `busy_o` is low. `busy_o` is high from the next cycle until the edge on which the last frame's `cs_n_o` rises. On that edge `busy_o` falls and `done_o` is high for exactly one cycle.
- R8: Requests of any kind that arrive while `busy_o` is high are ignored.
- R9: When several requests arrive on the same edge, power-down wins over power-up, and power-up wins over a command write.
- R10: `miso_i` has no effect on any output.
- R11: During and right after reset, `cs_n_o`=1, `sck_o`=1, `mosi_o`=0, `busy_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Single register write request |
| cmd_reg_i | input | 8 | Register number for the command write |
| cmd_val_i | input | 16 | Value for the command write |
| pwr_up_i | input | 1 | Power-up sequence request |
| pwr_dn_i | input | 1 | Power-down request |
| miso_i | input | 1 | Serial data from the panel (unused) |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the panel |
| cs_n_o | output | 1 | Chip select, active low |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |

## Verification
A wrong bit counter or shift register shows up on the next chip-select pulse, as a frame whose length or content is wrong. It is caught when that frame closes, roughly 150 clock cycles after the fault. A wrong sequencer phase or write slot shows up as frames swapped or missing within the same request. It also shows up as `busy_o` falling early or late, which is visible at the request's last chip-select rise. Accept logic that ignores `busy_o` shows up as extra frames that the frame count catches.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;
  localparam int unsigned FRAME_W = 24;

  localparam logic [7:0]  IDX_LEAD  = 8'h74;
  localparam logic [7:0]  DAT_LEAD  = 8'h76;
  localparam logic [7:0]  REG_SHUT  = 8'h11;
  localparam logic [7:0]  REG_DRV   = 8'h01;
  localparam logic [15:0] SHUT_ON   = 16'h0000;
  localparam logic [15:0] SHUT_OFF  = 16'h0001;
  localparam logic [15:0] DRV_MASK  = 16'h2B00;
  localparam logic [15:0] DRV_FIXED = 16'h2AEF;

  typedef struct packed {
    logic [7:0]  addr;
    logic [15:0] val;
  } reg_wr_t;

  function automatic logic [FRAME_W-1:0] index_frame(reg_wr_t w);
    return {IDX_LEAD, 8'h00, w.addr};
  endfunction

  function automatic logic [FRAME_W-1:0] data_frame(reg_wr_t w);
    return {DAT_LEAD, w.val};
  endfunction
endpackage

// File: rtl/spi_frame_tx.sv
module spi_frame_tx #(
  parameter int unsigned HALF_DIV = 3,
  parameter int unsigned FRAME_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               cs_n_o,
  output logic               frame_end_o
);
  localparam int unsigned CW = $clog2(2 * HALF_DIV) + 1;
  localparam int unsigned BW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(2 * HALF_DIV - 1);
  localparam logic [BW-1:0] BITS_ALL  = BW'(FRAME_W);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SETUP, S_LOW, S_HIGH} tx_state_e;

  tx_state_e          state_q;
  logic [CW-1:0]      cnt_q;
  logic [BW-1:0]      bits_q;
  logic [FRAME_W-1:0] sh_q;

  assign frame_end_o = (state_q == S_HIGH) && (cnt_q == HALF_LAST) && (bits_q == BITS_ALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      sck_o   <= 1'b1;
      mosi_o  <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (start_i) begin
            sh_q    <= frame_i;
            state_q <= S_LEAD;
          end
        end
        // guaranteed CS_n high gap before every frame
        S_LEAD: if (cnt_q == LEAD_LAST) begin
          cs_n_o  <= 1'b0;
          cnt_q   <= '0;
          state_q <= S_SETUP;
        end
        S_SETUP: if (cnt_q == HALF_LAST) begin
          sck_o   <= 1'b0;
          mosi_o  <= sh_q[FRAME_W-1];
          sh_q    <= sh_q << 1;
          bits_q  <= '0;
          cnt_q   <= '0;
          state_q <= S_LOW;
        end
        S_LOW: if (cnt_q == HALF_LAST) begin
          sck_o   <= 1'b1;
          bits_q  <= bits_q + 1'b1;
          cnt_q   <= '0;
          state_q <= S_HIGH;
        end
        S_HIGH: if (cnt_q == HALF_LAST) begin
          cnt_q <= '0;
          if (bits_q == BITS_ALL) begin
            cs_n_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            sck_o   <= 1'b0;
            mosi_o  <= sh_q[FRAME_W-1];
            sh_q    <= sh_q << 1;
            state_q <= S_LOW;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1
  sck_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> sck_o);
  // R1
  no_rise_outside_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> !cs_n_o);
  // R2
  full_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> $past(bits_q) == BITS_ALL);
endmodule

// File: rtl/panel_spi_seq.sv
module panel_spi_seq
  import panel_spi_pkg::*;
#(
  parameter logic [15:0] DRV_MODE = 16'h2A00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [7:0]         cmd_reg_i,
  input  logic [15:0]        cmd_val_i,
  input  logic               pwr_up_i,
  input  logic               pwr_dn_i,
  input  logic               frame_end_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam logic [15:0] DRV_VAL = (DRV_MODE & DRV_MASK) | (DRV_FIXED & ~DRV_MASK);

  reg_wr_t wr0_q, wr1_q, cur;
  logic    two_q, sel_q, data_ph_q;
  logic    any_req;

  assign any_req = cmd_valid_i | pwr_up_i | pwr_dn_i;
  assign cur     = sel_q ? wr1_q : wr0_q;
  assign frame_o = data_ph_q ? data_frame(cur) : index_frame(cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr0_q     <= '0;
      wr1_q     <= '0;
      two_q     <= 1'b0;
      sel_q     <= 1'b0;
      data_ph_q <= 1'b0;
      start_o   <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (!busy_o) begin
        if (any_req) begin
          busy_o    <= 1'b1;
          start_o   <= 1'b1;
          sel_q     <= 1'b0;
          data_ph_q <= 1'b0;
          two_q     <= 1'b0;
          if (pwr_dn_i) begin
            wr0_q <= '{addr: REG_SHUT, val: SHUT_OFF};
          end else if (pwr_up_i) begin
            wr0_q <= '{addr: REG_SHUT, val: SHUT_ON};
            wr1_q <= '{addr: REG_DRV,  val: DRV_VAL};
            two_q <= 1'b1;
          end else begin
            wr0_q <= '{addr: cmd_reg_i, val: cmd_val_i};
          end
        end
      end else if (frame_end_i) begin
        if (!data_ph_q) begin
          data_ph_q <= 1'b1;
          start_o   <= 1'b1;
        end else if (two_q && !sel_q) begin
          sel_q     <= 1'b1;
          data_ph_q <= 1'b0;
          start_o   <= 1'b1;
        end else begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R7
  done_on_busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  ignore_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !frame_end_i && any_req) |=> (busy_o && !start_o));
endmodule

// File: rtl/panel_spi_writer.sv
module panel_spi_writer
  import panel_spi_pkg::*;
#(
  parameter int unsigned HALF_DIV = 3,
  parameter logic [15:0] DRV_MODE = 16'h2A00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [7:0]  cmd_reg_i,
  input  logic [15:0] cmd_val_i,
  input  logic        pwr_up_i,
  input  logic        pwr_dn_i,
  input  logic        miso_i,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        cs_n_o,
  output logic        busy_o,
  output logic        done_o
);
  logic               start;
  logic               frame_end;
  logic [FRAME_W-1:0] frame;
  logic               unused_miso;

  assign unused_miso = miso_i;

  panel_spi_seq #(.DRV_MODE(DRV_MODE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_reg_i  (cmd_reg_i),
    .cmd_val_i  (cmd_val_i),
    .pwr_up_i   (pwr_up_i),
    .pwr_dn_i   (pwr_dn_i),
    .frame_end_i(frame_end),
    .start_o    (start),
    .frame_o    (frame),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  spi_frame_tx #(.HALF_DIV(HALF_DIV), .FRAME_W(FRAME_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .frame_i    (frame),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .cs_n_o     (cs_n_o),
    .frame_end_o(frame_end)
  );

  // R7
  idle_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);
  // R7
  done_at_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !$past(cs_n_o)));
endmodule

// File: tb/panel_spi_writer_bench.sv
module panel_spi_writer_bench;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_reg_i = '0;
  logic [15:0] cmd_val_i = '0;
  logic        pwr_up_i = 1'b0;
  logic        pwr_dn_i = 1'b0;
  logic        miso_i = 1'b0;
  logic        sck_o, mosi_o, cs_n_o, busy_o, done_o;

  always #5 clk = ~clk;

  panel_spi_writer #(.HALF_DIV(HALF), .DRV_MODE(16'h2A00)) u_panel_spi_writer (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_reg_i(cmd_reg_i),
    .cmd_val_i(cmd_val_i), .pwr_up_i(pwr_up_i), .pwr_dn_i(pwr_dn_i), .miso_i(miso_i),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0, failures = 0;

  // frame monitor
  logic [23:0] cap = '0;
  logic [23:0] frames [64];
  int nbits = 0, nframes = 0, bad_len = 0, hi_cnt = 0, gap_min = 1000, sck_err = 0;
  bit in_frame = 0;

  always @(posedge sck_o) if (rst_ni && !cs_n_o) begin
    cap = {cap[22:0], mosi_o};
    nbits++;
  end
  always @(negedge cs_n_o) if (rst_ni) begin
    if (nframes > 0 && hi_cnt < gap_min) gap_min = hi_cnt;
    in_frame = 1;
    nbits = 0;
  end
  always @(posedge cs_n_o) if (rst_ni && in_frame) begin
    if (nbits != 24) bad_len++;
    if (nframes < 64) frames[nframes] = cap;
    nframes++;
    in_frame = 0;
  end
  always @(posedge clk) hi_cnt <= cs_n_o ? hi_cnt + 1 : 0;
  always @(negedge clk) if (rst_ni && cs_n_o && !sck_o) sck_err++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit dn, input bit up, input bit cv, input logic [7:0] r,
                       input logic [15:0] v);
    @(negedge clk);
    pwr_dn_i = dn; pwr_up_i = up; cmd_valid_i = cv; cmd_reg_i = r; cmd_val_i = v;
    @(negedge clk);
    pwr_dn_i = 0; pwr_up_i = 0; cmd_valid_i = 0;
    chk(busy_o === 1'b1, "R7 busy after accept", busy_o, 1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (busy_o === 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(done_o === 1'b1 && cs_n_o === 1'b1, "R7 done with cs rise", {done_o, cs_n_o}, 3);
    @(negedge clk);
    chk(done_o === 1'b0, "R7 done one cycle", done_o, 0);
  endtask

  task automatic expect_wr(input int base, input logic [7:0] r, input logic [15:0] v,
                           input string tag);
    chk(frames[base] == {8'h74, 8'h00, r}, {tag, " index frame"}, frames[base],
        {8'h74, 8'h00, r});
    chk(frames[base+1] == {8'h76, v}, {tag, " data frame"}, frames[base+1], {8'h76, v});
  endtask

  task automatic t_reset();
    chk({cs_n_o, sck_o, mosi_o, busy_o, done_o} === 5'b11000, "R11 reset outputs",
        {cs_n_o, sck_o, mosi_o, busy_o, done_o}, 5'b11000);
  endtask

  task automatic t_write(input logic [7:0] r, input logic [15:0] v);
    int base = nframes;
    issue(0, 0, 1, r, v);
    wait_done();
    chk(nframes == base + 2, "R3 frame count", nframes - base, 2);
    expect_wr(base, r, v, "R3");
  endtask

  task automatic t_power_up();
    int base = nframes;
    issue(0, 1, 0, 8'h00, 16'h0000);
    wait_done();
    chk(nframes == base + 4, "R5 frame count", nframes - base, 4);
    expect_wr(base, 8'h11, 16'h0000, "R5 on");
    expect_wr(base + 2, 8'h01, 16'h2AEF, "R5 drv");
  endtask

  task automatic t_power_dn();
    int base = nframes;
    issue(1, 0, 0, 8'h00, 16'h0000);
    wait_done();
    chk(nframes == base + 2, "R6 frame count", nframes - base, 2);
    expect_wr(base, 8'h11, 16'h0001, "R6");
  endtask

  task automatic t_ignore();
    int base = nframes;
    issue(0, 0, 1, 8'h33, 16'h1234);
    repeat (40) @(negedge clk);
    pwr_dn_i = 1; pwr_up_i = 1; cmd_valid_i = 1; cmd_reg_i = 8'h44; cmd_val_i = 16'h9999;
    @(negedge clk);
    pwr_dn_i = 0; pwr_up_i = 0; cmd_valid_i = 0;
    wait_done();
    repeat (30) @(negedge clk);
    chk(busy_o === 1'b0 && nframes == base + 2, "R8 busy request ignored", nframes - base, 2);
    expect_wr(base, 8'h33, 16'h1234, "R8");
  endtask

  task automatic t_priority();
    int base = nframes;
    issue(1, 1, 1, 8'h22, 16'h5555);
    wait_done();
    chk(nframes == base + 2, "R9 dn wins count", nframes - base, 2);
    expect_wr(base, 8'h11, 16'h0001, "R9 dn wins");
    base = nframes;
    issue(0, 1, 1, 8'h22, 16'h5555);
    wait_done();
    chk(nframes == base + 4, "R9 up wins count", nframes - base, 4);
    expect_wr(base + 2, 8'h01, 16'h2AEF, "R9 up wins");
  endtask

  task automatic t_miso();
    int base = nframes;
    miso_i = 1'b1;
    issue(0, 0, 1, 8'hC3, 16'h0F0F);
    wait_done();
    miso_i = 1'b0;
    expect_wr(base, 8'hC3, 16'h0F0F, "R10 miso high");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(8'h5A, 16'hA55A);
    t_write(8'hFF, 16'hFFFF);
    t_write(8'h00, 16'h0000);
    t_write(8'h80, 16'h8001);
    t_power_up();
    t_power_dn();
    t_ignore();
    t_priority();
    t_miso();
    chk(bad_len == 0, "R2 24 bits per frame", bad_len, 0);
    chk(gap_min >= 2 * HALF, "R4 cs gap", gap_min, 2 * HALF);
    chk(sck_err == 0, "R1 sck idle high", sck_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule